// File: doc/BRIEF.md
# Address Match Strobe Generator

This block sequences the control lines of an external content-addressable memory that looks up the two address fields of each received frame. A frame is announced by a one-cycle start pulse on the starting-delimiter byte. The frame control byte follows, then the destination address bytes, then the source address bytes. The block counts byte positions from that pulse. It issues a load strobe in the cycle just before each address field, and it raises one of two select lines while the bytes of that field pass. It samples the memory's hit line at a fixed delay after each strobe and keeps the results in two flags. A copy-permission output combines the destination flag with a frame abort input.

Two timing modes exist. In normal mode each strobe lasts one cycle. In extended mode each strobe lasts two cycles and the hit line is sampled later, which gives a slow memory more time. The mode is taken when a frame starts. A hold bit, set by reset and written through a configuration strobe, suppresses all strobes and sampling until firmware clears it. Token frames carry no addresses and cause no activity.

Top module: `addr_cam_ctrl`

## Requirements
- R1: Position p counts cycles after the start pulse, with the start cycle as p=0. With N address bytes, the destination field occupies p=2..N+1 and the source field occupies p=N+2..2N+1. In normal mode `cam_load` is high for exactly one cycle at p=1 and again at p=N+1.
- R2: In extended mode `cam_load` is high at p=1 and p=2, and again at p=N+1 and p=N+2.
- R3: `sel_da` is high for p=2..N+1 and `sel_sa` is high for p=N+2..2N+1. Both are low at every other cycle, and the two are never high together.
- R4: With lag L (LAT_NORM in normal mode, LAT_EXT in extended mode), `cam_hit` is sampled at p=1+L for the destination and at p=N+1+L for the source. Each result appears on `da_hit` or `sa_hit` from the next cycle onward.
- R5: Reset sets the hold bit to 1. Writing through `cfg_we` loads the bit from `cfg_hold`. While the bit is 1, `cam_load` stays low and no sample is taken, so both flags stay 0.
- R6: A start pulse with `frame_token` high produces no strobe, no select and no sampling.
- R7: Both match flags read 0 in the cycle after every start pulse.
- R8: `rx_abort` high at a live position p ends the frame. From p+1 there is no strobe, no select and no further sampling. A sample due at p itself is still taken.
- R9: `copy_ok` equals `da_hit` while no abort has occurred in the current frame, and is 0 after an abort until the next start pulse.
- R10: The mode is taken from `ext_mode` on the start pulse. Changes to `ext_mode` later in the frame have no effect on that frame.
- R11: After reset, all outputs are low.

Parameters: ADDR_BYTES (N, default 6), LAT_NORM (default 2), LAT_EXT (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse on the starting-delimiter byte |
| frame_token | input | 1 | Qualifies `frame_start`: the frame is a token |
| ext_mode | input | 1 | Extended timing mode, taken at `frame_start` |
| rx_abort | input | 1 | Abandon the current frame |
| cam_hit | input | 1 | Match result from the external memory |
| cfg_we | input | 1 | Write strobe for the hold bit |
| cfg_hold | input | 1 | New value of the hold bit |
| cam_load | output | 1 | Load strobe to the memory |
| sel_da | output | 1 | Destination field is being presented |
| sel_sa | output | 1 | Source field is being presented |
| da_hit | output | 1 | Destination address matched |
| sa_hit | output | 1 | Source address matched |
| copy_ok | output | 1 | Destination matched and frame not aborted |

## Verification
The assertions assume that a new start pulse never arrives while a frame is still live, which is up to position max(2N+1, N+1+LAT_EXT). They also assume that the hold bit is not rewritten in the middle of a frame. The stimulus meets both conditions: each frame runs two cycles beyond its last live position before the next start pulse, and the hold bit is written only between frames. Abort pulses are issued only at live positions. `ext_mode` is deliberately inverted right after every start pulse to check R10.

// File: rtl/addr_cam_pkg.sv
package addr_cam_pkg;

  // Last live position of a frame, counted from the start pulse (p=0).
  function automatic int unsigned frame_last_pos(int unsigned nbytes,
                                                 int unsigned lat_n,
                                                 int unsigned lat_e);
    int unsigned lat_max;
    int unsigned sel_end;
    int unsigned smp_end;
    lat_max = (lat_n > lat_e) ? lat_n : lat_e;
    sel_end = 2 * nbytes + 1;
    smp_end = nbytes + 1 + lat_max;
    return (sel_end > smp_end) ? sel_end : smp_end;
  endfunction

  // Position at which the hit line is sampled for a strobe starting at strobe_at.
  function automatic int unsigned hit_sample_pos(int unsigned strobe_at,
                                                 int unsigned lag);
    return strobe_at + lag;
  endfunction

endpackage

// File: rtl/addr_field_seq.sv
module addr_field_seq #(
  parameter int unsigned NB   = 6,
  parameter int unsigned LAST = 13,
  parameter int unsigned PW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          frame_token,
  input  logic          ext_mode,
  input  logic          abort_req,
  output logic [PW-1:0] pos_o,
  output logic          live_o,
  output logic          ext_o,
  output logic          sel_da_o,
  output logic          sel_sa_o
);
  localparam logic [PW-1:0] P_LAST   = PW'(LAST);
  localparam logic [PW-1:0] P_DA_LO  = PW'(2);
  localparam logic [PW-1:0] P_DA_HI  = PW'(NB + 1);
  localparam logic [PW-1:0] P_SA_LO  = PW'(NB + 2);
  localparam logic [PW-1:0] P_SA_HI  = PW'(2 * NB + 1);

  logic [PW-1:0] pos_q;
  logic          live_q;
  logic          ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      live_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (frame_start) begin
      pos_q  <= PW'(1);
      live_q <= !frame_token;
      ext_q  <= ext_mode;
    end else if (live_q) begin
      if (abort_req || pos_q == P_LAST) begin
        live_q <= 1'b0;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  assign pos_o    = pos_q;
  assign live_o   = live_q;
  assign ext_o    = ext_q;
  assign sel_da_o = live_q && (pos_q >= P_DA_LO) && (pos_q <= P_DA_HI);
  assign sel_sa_o = live_q && (pos_q >= P_SA_LO) && (pos_q <= P_SA_HI);

endmodule

// File: rtl/addr_strobe_gen.sv
module addr_strobe_gen
  import addr_cam_pkg::*;
#(
  parameter int unsigned NB       = 6,
  parameter int unsigned LAT_NORM = 2,
  parameter int unsigned LAT_EXT  = 4,
  parameter int unsigned PW       = 4
) (
  input  logic [PW-1:0] pos_i,
  input  logic          live_i,
  input  logic          ext_i,
  input  logic          hold_i,
  output logic          load_o,
  output logic          smp_da_o,
  output logic          smp_sa_o
);
  localparam int unsigned DA_STB = 1;
  localparam int unsigned SA_STB = NB + 1;

  localparam logic [PW-1:0] P_DA_STB  = PW'(DA_STB);
  localparam logic [PW-1:0] P_SA_STB  = PW'(SA_STB);
  localparam logic [PW-1:0] P_DA_STB2 = PW'(DA_STB + 1);
  localparam logic [PW-1:0] P_SA_STB2 = PW'(SA_STB + 1);
  localparam logic [PW-1:0] P_DA_SN   = PW'(hit_sample_pos(DA_STB, LAT_NORM));
  localparam logic [PW-1:0] P_DA_SE   = PW'(hit_sample_pos(DA_STB, LAT_EXT));
  localparam logic [PW-1:0] P_SA_SN   = PW'(hit_sample_pos(SA_STB, LAT_NORM));
  localparam logic [PW-1:0] P_SA_SE   = PW'(hit_sample_pos(SA_STB, LAT_EXT));

  logic enable;
  logic first_cyc;
  logic second_cyc;

  assign enable     = live_i && !hold_i;
  assign first_cyc  = (pos_i == P_DA_STB) || (pos_i == P_SA_STB);
  assign second_cyc = (pos_i == P_DA_STB2) || (pos_i == P_SA_STB2);

  assign load_o   = enable && (first_cyc || (ext_i && second_cyc));
  assign smp_da_o = enable && (pos_i == (ext_i ? P_DA_SE : P_DA_SN));
  assign smp_sa_o = enable && (pos_i == (ext_i ? P_SA_SE : P_SA_SN));

endmodule

// File: rtl/addr_match_latch.sv
module addr_match_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic abort_live,
  input  logic smp_da,
  input  logic smp_sa,
  input  logic cam_hit,
  output logic da_hit_o,
  output logic sa_hit_o,
  output logic copy_ok_o
);
  logic da_q;
  logic sa_q;
  logic abrt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da_q   <= 1'b0;
      sa_q   <= 1'b0;
      abrt_q <= 1'b0;
    end else if (frame_start) begin
      da_q   <= 1'b0;
      sa_q   <= 1'b0;
      abrt_q <= 1'b0;
    end else begin
      if (smp_da)     da_q   <= cam_hit;
      if (smp_sa)     sa_q   <= cam_hit;
      if (abort_live) abrt_q <= 1'b1;
    end
  end

  assign da_hit_o  = da_q;
  assign sa_hit_o  = sa_q;
  assign copy_ok_o = da_q && !abrt_q;

endmodule

// File: rtl/addr_cam_ctrl.sv
module addr_cam_ctrl
  import addr_cam_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned LAT_NORM   = 2,
  parameter int unsigned LAT_EXT    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic frame_token,
  input  logic ext_mode,
  input  logic rx_abort,
  input  logic cam_hit,
  input  logic cfg_we,
  input  logic cfg_hold,
  output logic cam_load,
  output logic sel_da,
  output logic sel_sa,
  output logic da_hit,
  output logic sa_hit,
  output logic copy_ok
);
  localparam int unsigned LAST = frame_last_pos(ADDR_BYTES, LAT_NORM, LAT_EXT);
  localparam int unsigned PW   = $clog2(LAST + 2);

  logic [PW-1:0] frame_pos;
  logic          frame_live;
  logic          ext_q;
  logic          hold_q;
  logic          abort_live;
  logic          smp_da;
  logic          smp_sa;

  always_ff @(posedge clk) begin
    if (!rst_n)      hold_q <= 1'b1;
    else if (cfg_we) hold_q <= cfg_hold;
  end

  assign abort_live = frame_live && rx_abort;

  addr_field_seq #(.NB(ADDR_BYTES), .LAST(LAST), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_token(frame_token), .ext_mode(ext_mode), .abort_req(rx_abort),
    .pos_o(frame_pos), .live_o(frame_live), .ext_o(ext_q),
    .sel_da_o(sel_da), .sel_sa_o(sel_sa)
  );

  addr_strobe_gen #(.NB(ADDR_BYTES), .LAT_NORM(LAT_NORM), .LAT_EXT(LAT_EXT), .PW(PW)) u_stb (
    .pos_i(frame_pos), .live_i(frame_live), .ext_i(ext_q), .hold_i(hold_q),
    .load_o(cam_load), .smp_da_o(smp_da), .smp_sa_o(smp_sa)
  );

  addr_match_latch u_mat (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .abort_live(abort_live),
    .smp_da(smp_da), .smp_sa(smp_sa), .cam_hit(cam_hit),
    .da_hit_o(da_hit), .sa_hit_o(sa_hit), .copy_ok_o(copy_ok)
  );

  // R1: a normal-mode strobe lasts a single cycle
  assert_load_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cam_load && !ext_q && !frame_start) |=> !cam_load);

  // R2: an extended-mode strobe is held for a second cycle
  assert_load_double_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cam_load) && ext_q && !rx_abort && !cfg_we && !frame_start) |=> cam_load);

  // R3: the two field selects are exclusive
  assert_sel_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_da, sel_sa}));

  // R5: the hold bit blocks every strobe
  assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !cam_load);

  // R6: a token frame starts no activity
  assert_token_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_token) |=> (!cam_load && !sel_da && !sel_sa));

  // R7: flags clear on every new frame
  assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!da_hit && !sa_hit));

  // R8 and R9: an abort ends strobes and copy permission
  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_live && !frame_start) |=> (!cam_load && !copy_ok && !sel_da && !sel_sa));

endmodule

// File: tb/addr_cam_ctrl_tb.sv
`timescale 1ns/1ps
module addr_cam_ctrl_tb;
  localparam int NB   = 6;
  localparam int LN   = 2;
  localparam int LE   = 4;
  localparam int LAST = (2*NB+1 > NB+1+LE) ? 2*NB+1 : NB+1+LE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, frame_token = 1'b0, ext_mode = 1'b0;
  logic rx_abort = 1'b0, cam_hit = 1'b0, cfg_we = 1'b0, cfg_hold = 1'b0;
  logic cam_load, sel_da, sel_sa, da_hit, sa_hit, copy_ok;

  int checks = 0;
  int errors = 0;
  logic hold_model = 1'b1;

  always #10 clk = ~clk;

  addr_cam_ctrl #(.ADDR_BYTES(NB), .LAT_NORM(LN), .LAT_EXT(LE)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_token(frame_token),
    .ext_mode(ext_mode), .rx_abort(rx_abort), .cam_hit(cam_hit), .cfg_we(cfg_we),
    .cfg_hold(cfg_hold), .cam_load(cam_load), .sel_da(sel_da), .sel_sa(sel_sa),
    .da_hit(da_hit), .sa_hit(sa_hit), .copy_ok(copy_ok)
  );

  task automatic chk(string req, int c, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%0b expected=%0b", req, c, act, exp);
    end
  endtask

  task automatic write_hold(logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_hold = v;
    @(negedge clk);
    cfg_we = 1'b0;
    hold_model = v;
  endtask

  // ab < 0 means no abort
  task automatic run_frame(logic ext, logic tok, logic hda, logic hsa, int ab);
    int lag, sd, ss, live_end;
    lag = ext ? LE : LN;
    sd = 1 + lag;
    ss = NB + 1 + lag;
    live_end = (ab >= 0) ? ab : LAST;
    for (int c = 0; c <= LAST + 2; c++) begin
      logic live, exp_load, exp_da, exp_sa, exp_dh, exp_sh, aborted;
      @(negedge clk);
      live = !tok && c >= 1 && c <= live_end;
      exp_load = live && !hold_model &&
                 (c == 1 || c == NB+1 || (ext && (c == 2 || c == NB+2)));
      exp_da = live && c >= 2 && c <= NB+1;
      exp_sa = live && c >= NB+2 && c <= 2*NB+1;
      chk(ext ? "R2 load" : "R1 load", c, cam_load, exp_load);
      chk("R3 sel_da", c, sel_da, exp_da);
      chk("R3 sel_sa", c, sel_sa, exp_sa);
      if (c >= 1) begin
        exp_dh = !tok && !hold_model && sd <= live_end && c > sd && hda;
        exp_sh = !tok && !hold_model && ss <= live_end && c > ss && hsa;
        aborted = (ab >= 0) && (ab < c);
        if (c == 1) begin
          chk("R7 da_hit clear", c, da_hit, 1'b0);
          chk("R7 sa_hit clear", c, sa_hit, 1'b0);
        end
        chk(hold_model ? "R5 da_hit" : "R4 da_hit", c, da_hit, exp_dh);
        chk(hold_model ? "R5 sa_hit" : "R4 sa_hit", c, sa_hit, exp_sh);
        chk(aborted ? "R8 copy_ok" : "R9 copy_ok", c, copy_ok, exp_dh && !aborted);
      end
      frame_start = (c == 0);
      frame_token = tok;
      ext_mode    = (c == 0) ? ext : !ext;  // R10: later changes ignored
      rx_abort    = (c == ab);
      if (c == sd)      cam_hit = hda;
      else if (c == ss) cam_hit = hsa;
      else              cam_hit = (c <= NB+1) ? !hda : !hsa;
    end
    frame_start = 1'b0; rx_abort = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 cam_load", 0, cam_load, 1'b0);
    chk("R11 sel_da", 0, sel_da, 1'b0);
    chk("R11 sel_sa", 0, sel_sa, 1'b0);
    chk("R11 da_hit", 0, da_hit, 1'b0);
    chk("R11 sa_hit", 0, sa_hit, 1'b0);
    chk("R11 copy_ok", 0, copy_ok, 1'b0);
    rst_n = 1'b1;
    // R5: hold bit set from reset, sweep with it set
    for (int e = 0; e < 2; e++)
      for (int h = 0; h < 4; h++)
        run_frame(e[0], 1'b0, h[1], h[0], -1);
    write_hold(1'b0);
    // R1 R2 R4 R9 sweep over modes and hit patterns
    for (int e = 0; e < 2; e++)
      for (int h = 0; h < 4; h++)
        run_frame(e[0], 1'b0, h[1], h[0], -1);
    // R6: token frames after a matching frame
    run_frame(1'b0, 1'b0, 1'b1, 1'b1, -1);
    run_frame(1'b0, 1'b1, 1'b1, 1'b1, -1);
    run_frame(1'b1, 1'b1, 1'b1, 1'b1, -1);
    // R8: aborts at several positions
    for (int e = 0; e < 2; e++) begin
      run_frame(e[0], 1'b0, 1'b1, 1'b1, 1);
      run_frame(e[0], 1'b0, 1'b1, 1'b1, 3);
      run_frame(e[0], 1'b0, 1'b1, 1'b1, NB+1);
      run_frame(e[0], 1'b0, 1'b1, 1'b1, NB+3);
      run_frame(e[0], 1'b0, 1'b1, 1'b1, LAST);
    end
    // R5: setting the hold bit again suppresses strobes
    write_hold(1'b1);
    run_frame(1'b1, 1'b0, 1'b1, 1'b1, -1);
    run_frame(1'b0, 1'b0, 1'b1, 1'b0, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule